// File: doc/BRIEF.md
# Configuration Transaction Controller

This block lets software reach a small set of board-level configuration targets through three registers on a simple register bus: a data word, a control word and a two-bit status word. Software fills the data word, then writes the control word with its launch bit set. The block decodes the control fields and carries out one transaction: it reads or updates an entry in an internal table of oscillator frequencies, returns a fixed or parameterised supply voltage, or raises a system request such as shutdown or reboot. When the transaction has committed, the status word shows completion and whether the request was refused.

Reads return their result in the data word. Writes take their operand from the data word as it stood at launch. Every transaction spends one cycle pending and commits on the next edge. The oscillator table holds six main-board entries with fixed reset frequencies and a parameterised number of daughter-board entries with parameterised reset values.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset the data, control and status words read as zero, both request outputs are low, and the six main-board oscillator entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 in device order. Daughter-board entries hold their parameter values.
- R2: The data word is at byte address 0xA0, the control word at 0xA4 and the status word at 0xA8. A control write stores the written value with bits 31, 19 and 18 cleared. A control write with bit 31 clear launches nothing.
- R3: A status write keeps only bits 1:0 of the written value. Reads return them in bits 1:0 with zeros above.
- R4: A read of any other address returns zero. A write to any other address changes none of the three words.
- R5: A control write with bit 31 set launches a transaction. The status reads 0 during the following cycle. After the next edge the status bit 0 (complete) is set.
- R6: Control fields are: bit 30 write (1) or read (0), bits 29:26 channel, 25:20 function, 17:16 site, 15:12 position, 11:0 device. A transaction is refused unless channel and position are zero and site is 0 (main board) or 1 (daughter board). A refused transaction sets status to 3 and changes no table entry.
- R7: Function 1 read on site 0 with device below 6 returns that main-board oscillator entry in the data word, with status 1.
- R8: Function 1 write stores the data word into the addressed oscillator entry, leaves the data word unchanged and sets status 1.
- R9: On site 1, function 1 addresses daughter-board entries with device below the daughter count. A higher device is refused.
- R10: Function 2 read returns 3300000 for site 0 device 0, and the parameterised daughter value for site 1 with device below the daughter voltage count. Any other device, and any function 2 write, is refused.
- R11: A write of function 8 (shutdown) or 9 (reboot) to site 0 device 0 raises shutdown_req or reboot_req for exactly one cycle, the cycle after commit. The same code as a read, or on another device, is refused and raises nothing.
- R12: A write of function 7 (video source select) or 11 (display mode) to site 0 device 0 is accepted with status 1 and no other effect. Any other device, or a read, is refused.
- R13: A refused read leaves the data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the edge that takes the read |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
The assertions assume that software issues no write to the data, control or status word in the single cycle while a transaction is pending. The block ignores such writes, so a property that followed one would not hold. Reads are allowed in that cycle. The stimulus meets this by leaving an idle or read-only cycle after every launch. One sequence reads the status in exactly that cycle to observe the pending value.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

  localparam int WORD_W       = 32;
  localparam int DEV_W        = 12;
  localparam int MB_OSC_COUNT = 6;

  localparam logic [WORD_W-1:0] MAIN_VOLT_UV = 32'd3300000;
  localparam logic [WORD_W-1:0] CTRL_KEEP    = 32'h7FF3_FFFF;

  localparam logic [5:0] FN_OSC      = 6'd1;
  localparam logic [5:0] FN_VOLT     = 6'd2;
  localparam logic [5:0] FN_VSRC     = 6'd7;
  localparam logic [5:0] FN_SHUTDOWN = 6'd8;
  localparam logic [5:0] FN_REBOOT   = 6'd9;
  localparam logic [5:0] FN_DISPMODE = 6'd11;

  localparam logic [1:0] SITE_MAIN     = 2'd0;
  localparam logic [1:0] SITE_DAUGHTER = 2'd1;

  typedef struct packed {
    logic             launch;
    logic             wr;
    logic [3:0]       chan;
    logic [5:0]       func;
    logic [1:0]       unused;
    logic [1:0]       site;
    logic [3:0]       pos;
    logic [DEV_W-1:0] dev;
  } cfg_ctrl_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_OSC,
    ACT_VOLT,
    ACT_SHUTDOWN,
    ACT_REBOOT,
    ACT_ACCEPT
  } txn_act_e;

  function automatic logic [WORD_W-1:0] ctrl_store_value(input logic [WORD_W-1:0] w);
    return w & CTRL_KEEP;
  endfunction

  function automatic logic [WORD_W-1:0] main_osc_reset(input int idx);
    if (idx == 0) return 32'd50000000;
    if (idx == 1) return 32'd23750000;
    return 32'd24000000;
  endfunction

  function automatic logic [1:0] status_after(input logic ok);
    return {~ok, 1'b1};
  endfunction

endpackage

// File: rtl/cfg_txn_decode.sv
module cfg_txn_decode
  import cfg_txn_pkg::*;
#(
  parameter int DB_OSC_COUNT  = 2,
  parameter int DB_VOLT_COUNT = 2
) (
  input  cfg_ctrl_t ctrl,
  output logic      txn_ok,
  output txn_act_e  txn_act
);

  localparam logic [DEV_W-1:0] MB_OSC_LIM  = DEV_W'(MB_OSC_COUNT);
  localparam logic [DEV_W-1:0] DB_OSC_LIM  = DEV_W'(DB_OSC_COUNT);
  localparam logic [DEV_W-1:0] DB_VOLT_LIM = DEV_W'(DB_VOLT_COUNT);

  logic route_ok;
  logic on_main;
  logic main_dev0;
  logic osc_in_range;
  logic volt_in_range;

  always_comb begin
    on_main       = (ctrl.site == SITE_MAIN);
    route_ok      = (ctrl.chan == 4'd0) && (ctrl.pos == 4'd0) &&
                    (on_main || ctrl.site == SITE_DAUGHTER);
    main_dev0     = on_main && (ctrl.dev == '0);
    osc_in_range  = on_main ? (ctrl.dev < MB_OSC_LIM) : (ctrl.dev < DB_OSC_LIM);
    volt_in_range = on_main ? (ctrl.dev == '0) : (ctrl.dev < DB_VOLT_LIM);

    txn_act = ACT_NONE;
    if (route_ok) begin
      case (ctrl.func)
        FN_OSC:      if (osc_in_range) txn_act = ACT_OSC;
        FN_VOLT:     if (!ctrl.wr && volt_in_range) txn_act = ACT_VOLT;
        FN_VSRC,
        FN_DISPMODE: if (ctrl.wr && main_dev0) txn_act = ACT_ACCEPT;
        FN_SHUTDOWN: if (ctrl.wr && main_dev0) txn_act = ACT_SHUTDOWN;
        FN_REBOOT:   if (ctrl.wr && main_dev0) txn_act = ACT_REBOOT;
        default:     txn_act = ACT_NONE;
      endcase
    end
    txn_ok = (txn_act != ACT_NONE);
  end

endmodule

// File: rtl/cfg_osc_table.sv
module cfg_osc_table
  import cfg_txn_pkg::*;
#(
  parameter int                        DB_COUNT = 2,
  parameter logic [DB_COUNT*WORD_W-1:0] DB_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_daughter,
  input  logic [DEV_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mb_val [MB_OSC_COUNT];
  logic [WORD_W-1:0] db_val [DB_COUNT];

  for (genvar i = 0; i < MB_OSC_COUNT; i++) begin : g_main
    logic [WORD_W-1:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q <= main_osc_reset(i);
      end else if (wr_en && !sel_daughter && idx == DEV_W'(i)) begin
        entry_q <= wr_data;
      end
    end
    assign mb_val[i] = entry_q;
  end

  for (genvar j = 0; j < DB_COUNT; j++) begin : g_daughter
    logic [WORD_W-1:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q <= DB_INIT[j*WORD_W +: WORD_W];
      end else if (wr_en && sel_daughter && idx == DEV_W'(j)) begin
        entry_q <= wr_data;
      end
    end
    assign db_val[j] = entry_q;
  end

  always_comb begin
    rd_data = '0;
    if (sel_daughter) begin
      for (int k = 0; k < DB_COUNT; k++) begin
        if (idx == DEV_W'(k)) rd_data = db_val[k];
      end
    end else begin
      for (int k = 0; k < MB_OSC_COUNT; k++) begin
        if (idx == DEV_W'(k)) rd_data = mb_val[k];
      end
    end
  end

endmodule

// File: rtl/cfg_volt_source.sv
module cfg_volt_source
  import cfg_txn_pkg::*;
#(
  parameter int                         DB_COUNT = 2,
  parameter logic [DB_COUNT*WORD_W-1:0] DB_UV    = '0
) (
  input  logic              sel_daughter,
  input  logic [DEV_W-1:0]  idx,
  output logic [WORD_W-1:0] value
);

  always_comb begin
    value = '0;
    if (sel_daughter) begin
      for (int k = 0; k < DB_COUNT; k++) begin
        if (idx == DEV_W'(k)) value = DB_UV[k*WORD_W +: WORD_W];
      end
    end else if (idx == '0) begin
      value = MAIN_VOLT_UV;
    end
  end

endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_txn_pkg::*;
#(
  parameter int                              ADDR_W        = 12,
  parameter logic [ADDR_W-1:0]               ADDR_DATA     = ADDR_W'(12'hA0),
  parameter logic [ADDR_W-1:0]               ADDR_CTRL     = ADDR_W'(12'hA4),
  parameter logic [ADDR_W-1:0]               ADDR_STAT     = ADDR_W'(12'hA8),
  parameter int                              DB_OSC_COUNT  = 2,
  parameter logic [DB_OSC_COUNT*32-1:0]      DB_OSC_INIT   = {32'd40000000, 32'd60000000},
  parameter int                              DB_VOLT_COUNT = 2,
  parameter logic [DB_VOLT_COUNT*32-1:0]     DB_VOLT_UV    = {32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);

  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] ctrl_q;
  logic [1:0]        status_q;
  logic [WORD_W-1:0] rdata_q;
  logic              exec_pending;
  logic              shutdown_q;
  logic              reboot_q;

  cfg_ctrl_t         ctrl_f;
  logic              wr_data_hit;
  logic              wr_ctrl_hit;
  logic              wr_stat_hit;
  logic              launch;
  logic              txn_ok;
  txn_act_e          txn_act;
  logic [WORD_W-1:0] osc_rd;
  logic [WORD_W-1:0] volt_rd;
  logic              osc_we;
  logic              load_data;
  logic [WORD_W-1:0] read_result;
  logic [WORD_W-1:0] rd_mux;

  assign ctrl_f      = cfg_ctrl_t'(ctrl_q);
  assign wr_data_hit = bus_valid && bus_write && (bus_addr == ADDR_DATA);
  assign wr_ctrl_hit = bus_valid && bus_write && (bus_addr == ADDR_CTRL);
  assign wr_stat_hit = bus_valid && bus_write && (bus_addr == ADDR_STAT);
  assign launch      = wr_ctrl_hit && bus_wdata[31] && !exec_pending;

  cfg_txn_decode #(
    .DB_OSC_COUNT (DB_OSC_COUNT),
    .DB_VOLT_COUNT(DB_VOLT_COUNT)
  ) decode_i (
    .ctrl   (ctrl_f),
    .txn_ok (txn_ok),
    .txn_act(txn_act)
  );

  assign osc_we = exec_pending && (txn_act == ACT_OSC) && ctrl_f.wr;

  cfg_osc_table #(
    .DB_COUNT(DB_OSC_COUNT),
    .DB_INIT (DB_OSC_INIT)
  ) osc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (osc_we),
    .sel_daughter(ctrl_f.site == SITE_DAUGHTER),
    .idx         (ctrl_f.dev),
    .wr_data     (data_q),
    .rd_data     (osc_rd)
  );

  cfg_volt_source #(
    .DB_COUNT(DB_VOLT_COUNT),
    .DB_UV   (DB_VOLT_UV)
  ) volt_i (
    .sel_daughter(ctrl_f.site == SITE_DAUGHTER),
    .idx         (ctrl_f.dev),
    .value       (volt_rd)
  );

  assign read_result = (txn_act == ACT_OSC) ? osc_rd : volt_rd;
  assign load_data   = exec_pending && !ctrl_f.wr &&
                       (txn_act == ACT_OSC || txn_act == ACT_VOLT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      status_q     <= '0;
      exec_pending <= 1'b0;
      shutdown_q   <= 1'b0;
      reboot_q     <= 1'b0;
    end else begin
      exec_pending <= launch;
      shutdown_q   <= exec_pending && (txn_act == ACT_SHUTDOWN);
      reboot_q     <= exec_pending && (txn_act == ACT_REBOOT);
      if (exec_pending) begin
        status_q <= status_after(txn_ok);
        if (load_data) data_q <= read_result;
      end else begin
        if (wr_data_hit) data_q   <= bus_wdata;
        if (wr_ctrl_hit) ctrl_q   <= ctrl_store_value(bus_wdata);
        if (wr_stat_hit) status_q <= bus_wdata[1:0];
        if (launch)      status_q <= 2'b00;
      end
    end
  end

  always_comb begin
    if (bus_addr == ADDR_DATA)      rd_mux = data_q;
    else if (bus_addr == ADDR_CTRL) rd_mux = ctrl_q;
    else if (bus_addr == ADDR_STAT) rd_mux = {30'd0, status_q};
    else                            rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_valid && !bus_write) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign shutdown_req = shutdown_q;
  assign reboot_req   = reboot_q;

endmodule

// File: rtl/cfg_txn_ctrl_chk.sv
module cfg_txn_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        exec_pending,
  input logic        txn_ok,
  input logic        osc_we,
  input logic [31:0] ctrl_q,
  input logic [1:0]  status_q,
  input logic        shutdown_req,
  input logic        reboot_req
);

  assert_ctrl_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] == 1'b0) && (ctrl_q[19:18] == 2'b00));

  assert_launch_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (exec_pending && status_q == 2'b00));

  assert_single_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pending |=> (!exec_pending && status_q[0]));

  assert_refused_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_pending && !txn_ok) |=> (status_q == 2'b11));

  assert_accepted_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_pending && txn_ok) |=> (status_q == 2'b01));

  assert_commit_needs_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_we |-> (exec_pending && txn_ok));

  assert_shutdown_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  assert_reboot_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);

  assert_shutdown_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(exec_pending && txn_ok));

  assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reboot_req}));

endmodule

bind cfg_txn_ctrl cfg_txn_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .launch      (launch),
  .exec_pending(exec_pending),
  .txn_ok      (txn_ok),
  .osc_we      (osc_we),
  .ctrl_q      (ctrl_q),
  .status_q    (status_q),
  .shutdown_req(shutdown_req),
  .reboot_req  (reboot_req)
);

// File: tb/cfg_txn_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_txn_ctrl_tb_top;

  localparam logic [11:0] A_DATA = 12'hA0;
  localparam logic [11:0] A_CTRL = 12'hA4;
  localparam logic [11:0] A_STAT = 12'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        shutdown_req;
  logic        reboot_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic mon_inflight = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  cfg_txn_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic wr, input logic [3:0] chan, input logic [5:0] fn,
                                     input logic [1:0] site, input logic [3:0] pos, input logic [11:0] dev);
    return {1'b1, wr, chan, fn, 2'b00, site, pos, dev};
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // launch, then read status in the pending cycle
  task automatic launch_peek(input logic [31:0] c, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CTRL; bus_wdata = c;
    @(negedge clk);
    bus_write = 1'b0; bus_addr = A_STAT;
    exp_q.push_back(32'd0); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops expected items as read results appear
  always @(posedge clk) mon_inflight <= rst_n && bus_valid && !bus_write;
  always @(negedge clk) begin
    if (mon_inflight) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 shutdown low", {31'd0, shutdown_req}, 32'd0);
    check("R1 reboot low", {31'd0, reboot_req}, 32'd0);
    bus_rd(A_DATA, 32'd0, "R1 data reset");
    bus_rd(A_CTRL, 32'd0, "R1 ctrl reset");
    bus_rd(A_STAT, 32'd0, "R1 status reset");
    for (int d = 0; d < 6; d++) begin
      bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'(d)));
      bus_rd(A_DATA, (d == 0) ? 32'd50000000 : (d == 1) ? 32'd23750000 : 32'd24000000,
             "R1 main osc reset / R7 osc read");
    end
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd1, 4'd0, 12'd0));
    bus_rd(A_DATA, 32'd60000000, "R1 daughter osc reset");

    // R2 control store masking, no launch
    bus_wr(A_STAT, 32'd0);
    bus_wr(A_CTRL, 32'h7FFF_FFFF);
    bus_rd(A_CTRL, 32'h7FF3_FFFF, "R2 ctrl masked");
    bus_rd(A_STAT, 32'd0, "R2 no launch without bit31");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd1));
    bus_rd(A_CTRL, 32'h0010_0001, "R2 launch bit reads zero");

    // R3 status direct write
    bus_wr(A_STAT, 32'hFFFF_FFFE);
    bus_rd(A_STAT, 32'd2, "R3 status low bits");
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, 32'd3, "R3 status low bits all");

    // R4 unmapped
    bus_wr(A_DATA, 32'h1234_5678);
    bus_wr(12'h0B0, 32'hDEAD_BEEF);
    bus_wr(12'hA1, 32'h0BAD_F00D);
    bus_rd(12'h0B0, 32'd0, "R4 unmapped read");
    bus_rd(12'h000, 32'd0, "R4 unmapped read 0");
    bus_rd(A_DATA, 32'h1234_5678, "R4 data untouched");
    bus_rd(A_STAT, 32'd3, "R4 status untouched");

    // R5 pending then complete; R7 read
    launch_peek(mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd1), "R5 status pending");
    bus_rd(A_STAT, 32'd1, "R5 status complete");
    bus_rd(A_DATA, 32'd23750000, "R7 osc main dev1");

    // R8 osc write
    bus_wr(A_DATA, 32'd12345678);
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd1, 2'd0, 4'd0, 12'd3));
    bus_rd(A_STAT, 32'd1, "R8 write status");
    bus_rd(A_DATA, 32'd12345678, "R8 data unchanged by write");
    bus_wr(A_DATA, 32'd0);
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd3));
    bus_rd(A_DATA, 32'd12345678, "R8 readback dev3");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd2));
    bus_rd(A_DATA, 32'd24000000, "R8 neighbour dev2");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd6));
    bus_rd(A_STAT, 32'd3, "R7 main device 6 refused");

    // R9 daughter oscillators
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd1, 4'd0, 12'd1));
    bus_rd(A_DATA, 32'd40000000, "R9 daughter dev1");
    bus_wr(A_DATA, 32'd77);
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd1, 2'd1, 4'd0, 12'd0));
    bus_wr(A_DATA, 32'd0);
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd1, 4'd0, 12'd0));
    bus_rd(A_DATA, 32'd77, "R9 daughter write readback");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd1, 4'd0, 12'd2));
    bus_rd(A_STAT, 32'd3, "R9 daughter dev beyond count");

    // R10 voltage
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd2, 2'd0, 4'd0, 12'd0));
    bus_rd(A_DATA, 32'd3300000, "R10 main voltage");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd2, 2'd1, 4'd0, 12'd1));
    bus_rd(A_DATA, 32'd1000000, "R10 daughter voltage dev1");
    bus_rd(A_STAT, 32'd1, "R10 voltage status");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd2, 2'd0, 4'd0, 12'd1));
    bus_rd(A_STAT, 32'd3, "R10 main voltage dev1 refused");
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd2, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R10 voltage write refused");

    // R6 routing refusals, R13 data kept
    bus_wr(A_DATA, 32'hAAAA_5555);
    bus_wr(A_CTRL, mk(1'b0, 4'd1, 6'd1, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R6 channel nonzero");
    bus_rd(A_DATA, 32'hAAAA_5555, "R13 refused read keeps data");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd2, 12'd0));
    bus_rd(A_STAT, 32'd3, "R6 position nonzero");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd2, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R6 site 2");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd3, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R6 site 3");
    bus_wr(A_DATA, 32'd999);
    bus_wr(A_CTRL, mk(1'b1, 4'd1, 6'd1, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R6 refused write status");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd1, 2'd0, 4'd0, 12'd0));
    bus_rd(A_DATA, 32'd50000000, "R6 refused write no commit");

    // R11 shutdown / reboot pulses
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd8, 2'd0, 4'd0, 12'd0));
    @(negedge clk);
    check("R11 shutdown pulse", {31'd0, shutdown_req}, 32'd1);
    check("R11 no reboot with shutdown", {31'd0, reboot_req}, 32'd0);
    @(negedge clk);
    check("R11 shutdown one cycle", {31'd0, shutdown_req}, 32'd0);
    bus_rd(A_STAT, 32'd1, "R11 shutdown status");
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd9, 2'd0, 4'd0, 12'd0));
    @(negedge clk);
    check("R11 reboot pulse", {31'd0, reboot_req}, 32'd1);
    @(negedge clk);
    check("R11 reboot one cycle", {31'd0, reboot_req}, 32'd0);
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd8, 2'd0, 4'd0, 12'd0));
    @(negedge clk);
    check("R11 shutdown read no pulse", {31'd0, shutdown_req}, 32'd0);
    bus_rd(A_STAT, 32'd3, "R11 shutdown read refused");
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd9, 2'd0, 4'd0, 12'd1));
    @(negedge clk);
    check("R11 reboot dev1 no pulse", {31'd0, reboot_req}, 32'd0);
    bus_rd(A_STAT, 32'd3, "R11 reboot dev1 refused");

    // R12 video source / display mode
    bus_wr(A_DATA, 32'h0000_0042);
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd7, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd1, "R12 video source accepted");
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd11, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd1, "R12 display mode accepted");
    bus_rd(A_DATA, 32'h0000_0042, "R12 data unchanged");
    bus_wr(A_CTRL, mk(1'b1, 4'd0, 6'd7, 2'd0, 4'd0, 12'd1));
    bus_rd(A_STAT, 32'd3, "R12 video source dev1 refused");
    bus_wr(A_CTRL, mk(1'b0, 4'd0, 6'd11, 2'd0, 4'd0, 12'd0));
    bus_rd(A_STAT, 32'd3, "R12 display mode read refused");

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule